// File: doc/BRIEF.md
# Latched 64-bit System Timer

This block is a memory-mapped system timer. It runs a free 64-bit tick counter behind a programmable prescaler. Six 32-bit compare channels watch the low word of that count. A snapshot command copies the whole 64-bit count into a pair of holding registers in one clock, so software can read the two halves one after the other and still get a matching pair. Software can preset either half of the running count, for example to zero at start-up or to a saved value after a power transition.

A channel whose match register equals the low word at the moment the counter advances sets a sticky status bit. Software clears that bit by writing a one to it. The interrupt line of a channel is the status bit gated by that channel's enable. The last channel also serves as a watchdog: with the watchdog enable set, a hit on that channel drives the watchdog reset output until software clears its status bit.

Registers sit on 32-bit word boundaries (byte address / 4 gives the word index): count low 0x00, count high 0x04, match n at 0x08 + 4n, status 0x20, interrupt enable 0x24, watchdog enable 0x28 (bit 0), divider 0x2C, snapshot command 0x30 (bit 0), snapshot low 0x34, snapshot high 0x38. Writes take effect at the next rising clock edge. Reads are combinational from the current register values.

Top module: `sys_timer`

## Requirements
- R1: After reset the status, interrupt enable, watchdog enable, divider, match and snapshot registers all read zero, the count high word reads zero, `tmr_irq` and `wdog_rst` are low, and any unmapped or misaligned address reads zero.
- R2: With divider value D, the count advances once every 2*(D+1) clock cycles.
- R3: A write to the count low or count high word loads that half at the next edge. A software write wins over a tick that falls in the same cycle, and that tick is dropped.
- R4: When the low word wraps from 0xFFFFFFFF to 0, the high word increments at the same clock edge.
- R5: Writing bit 0 = 1 to the snapshot command copies the pre-edge 64-bit count into the snapshot low/high registers. Those registers then hold still while the counter runs. A command write with bit 0 = 0 leaves them unchanged.
- R6: When the counter advances to a low word equal to match n, status bit n is set at that same edge. The bit is set once per hit: if it is cleared while the count stays at the match value, it stays clear.
- R7: Writing 1 to status bit n clears it. Writing 0 leaves it unchanged. A hit in the same cycle as a clear wins.
- R8: `tmr_irq[n]` is high exactly when status bit n and interrupt enable bit n are both set.
- R9: With watchdog enable bit 0 set, a hit on channel 5 raises `wdog_rst`. With it clear, a hit sets status bit 5 only.
- R10: Compare uses only the low 32 bits of the count. It matches whatever the high word holds, and a match value already passed is not hit until the low word comes round again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tmr_irq | output | NUM_CH | Per-channel interrupt, status gated by enable |
| wdog_rst | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with six channels and an 8-bit divider field. Divider values up to 255 then give tick periods of 2 to 512 clocks, long enough for the bench to clear a status bit while the count still sits on its match value. It presets the low word just below 0xFFFFFFFF, which brings the high-word carry within a few cycles without counting through the full range. It uses back-to-back count writes at divider zero, so one write is certain to land on a tick.

// File: rtl/sys_tmr_pkg.sv
package sys_tmr_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 6;

  localparam logic [IDX_W-1:0] IX_CNT_LO  = 6'd0;
  localparam logic [IDX_W-1:0] IX_CNT_HI  = 6'd1;
  localparam logic [IDX_W-1:0] IX_MATCH0  = 6'd2;
  localparam logic [IDX_W-1:0] IX_STATUS  = 6'd8;
  localparam logic [IDX_W-1:0] IX_IRQ_EN  = 6'd9;
  localparam logic [IDX_W-1:0] IX_WDOG_EN = 6'd10;
  localparam logic [IDX_W-1:0] IX_DIV     = 6'd11;
  localparam logic [IDX_W-1:0] IX_SNAP    = 6'd12;
  localparam logic [IDX_W-1:0] IX_SNAP_LO = 6'd13;
  localparam logic [IDX_W-1:0] IX_SNAP_HI = 6'd14;

  typedef struct packed {
    logic              lo_we;
    logic              hi_we;
    logic [WORD_W-1:0] data;
  } cnt_wr_t;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int LIM_W = DIV_W + 1;

  logic [LIM_W-1:0] pcnt_q, pcnt_d;
  logic [LIM_W-1:0] limit;
  logic             tick;

  // terminal count 2*D+1 gives a period of 2*(D+1)
  assign limit = {div_i, 1'b1};
  assign tick  = (pcnt_q >= limit);

  always_comb begin
    if (tick) pcnt_d = '0;
    else      pcnt_d = pcnt_q + LIM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  assign tick_o = tick;

  // the shortest period is two cycles, so ticks never sit back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/tmr_count64.sv
module tmr_count64
  import sys_tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  cnt_wr_t           wr_i,
  input  logic              snap_i,
  output logic [WORD_W-1:0] cnt_lo_o,
  output logic [WORD_W-1:0] cnt_hi_o,
  output logic [WORD_W-1:0] snap_lo_o,
  output logic [WORD_W-1:0] snap_hi_o,
  output logic              inc_o,
  output logic [WORD_W-1:0] next_lo_o
);
  logic [WORD_W-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [WORD_W-1:0] slo_q, slo_d, shi_q, shi_d;
  logic              inc, wrap;
  logic [WORD_W-1:0] lo_inc;

  assign inc    = tick_i && !(wr_i.lo_we || wr_i.hi_we);
  assign lo_inc = lo_q + WORD_W'(1);
  assign wrap   = (lo_q == '1);

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    if (wr_i.lo_we || wr_i.hi_we) begin
      if (wr_i.lo_we) lo_d = wr_i.data;
      if (wr_i.hi_we) hi_d = wr_i.data;
    end else if (inc) begin
      lo_d = lo_inc;
      if (wrap) hi_d = hi_q + WORD_W'(1);
    end
  end

  always_comb begin
    slo_d = slo_q;
    shi_d = shi_q;
    if (snap_i) begin
      slo_d = lo_q;
      shi_d = hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      slo_q <= '0;
      shi_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      slo_q <= slo_d;
      shi_q <= shi_d;
    end
  end

  assign cnt_lo_o  = lo_q;
  assign cnt_hi_o  = hi_q;
  assign snap_lo_o = slo_q;
  assign snap_hi_o = shi_q;
  assign inc_o     = inc;
  assign next_lo_o = lo_inc;

  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i.lo_we && !wr_i.hi_we) |=> (lo_q == $past(lo_q) + WORD_W'(1)));

  p_wr_prio_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i.lo_we |=> (lo_q == $past(wr_i.data)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_i.lo_we && !wr_i.hi_we) |=> ($stable(lo_q) && $stable(hi_q)));

  p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wr_i.lo_we && !wr_i.hi_we && lo_q == '1)
      |=> (lo_q == '0 && hi_q == $past(hi_q) + WORD_W'(1)));

  p_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    snap_i |=> (slo_q == $past(lo_q) && shi_q == $past(hi_q)));

  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> ($stable(slo_q) && $stable(shi_q)));
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import sys_tmr_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           inc_i,
  input  logic [WORD_W-1:0]              next_lo_i,
  input  logic [NUM_CH-1:0]              match_we_i,
  input  logic [WORD_W-1:0]              wdata_i,
  input  logic [NUM_CH-1:0]              clr_i,
  output logic [NUM_CH-1:0][WORD_W-1:0]  match_o,
  output logic [NUM_CH-1:0]              status_o
);
  logic [NUM_CH-1:0][WORD_W-1:0] mat_q, mat_d;
  logic [NUM_CH-1:0]             stat_q, stat_d;
  logic [NUM_CH-1:0]             hit;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    // a hit is judged against the value the low word is about to take
    assign hit[n] = inc_i && (next_lo_i == mat_q[n]);

    always_comb begin
      mat_d[n]  = match_we_i[n] ? wdata_i : mat_q[n];
      stat_d[n] = hit[n] || (stat_q[n] && !clr_i[n]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mat_q[n]  <= '0;
        stat_q[n] <= 1'b0;
      end else begin
        mat_q[n]  <= mat_d[n];
        stat_q[n] <= stat_d[n];
      end
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[n] && !clr_i[n]) |=> stat_q[n]);

    p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !stat_q[n]) |=> !stat_q[n]);

    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[n] && clr_i[n] && !hit[n]) |=> !stat_q[n]);
  end

  assign match_o  = mat_q;
  assign status_o = stat_q;
endmodule

// File: rtl/sys_timer.sv
module sys_timer
  import sys_tmr_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int DIV_W   = 16,
  parameter int WDOG_CH = NUM_CH - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [NUM_CH-1:0] tmr_irq,
  output logic              wdog_rst
);
  logic                          rst_q_n;
  logic                          tick;
  logic                          aligned;
  logic [IDX_W-1:0]              idx;
  cnt_wr_t                       cnt_wr;
  logic                          snap_cmd;
  logic [WORD_W-1:0]             cnt_lo, cnt_hi, snap_lo, snap_hi, next_lo;
  logic                          inc;
  logic [NUM_CH-1:0]             match_we, clr;
  logic [NUM_CH-1:0][WORD_W-1:0] match;
  logic [NUM_CH-1:0]             status;
  logic [NUM_CH-1:0]             ie_q, ie_d;
  logic                          wden_q, wden_d;
  logic [DIV_W-1:0]              div_q, div_d;

  initial begin
    if (NUM_CH < 1 || NUM_CH > 6)
      $error("sys_timer: NUM_CH must lie in 1..6");
  end

  tmr_rst_sync u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_q_n)
  );

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign idx     = reg_addr[7:2];

  // write decode
  always_comb begin
    cnt_wr.lo_we = reg_we && aligned && (idx == IX_CNT_LO);
    cnt_wr.hi_we = reg_we && aligned && (idx == IX_CNT_HI);
    cnt_wr.data  = reg_wdata;
    snap_cmd     = reg_we && aligned && (idx == IX_SNAP) && reg_wdata[0];
    clr          = (reg_we && aligned && idx == IX_STATUS) ? reg_wdata[NUM_CH-1:0] : '0;
    for (int n = 0; n < NUM_CH; n++)
      match_we[n] = reg_we && aligned && (idx == IX_MATCH0 + IDX_W'(n));
  end

  // control registers
  always_comb begin
    ie_d   = ie_q;
    wden_d = wden_q;
    div_d  = div_q;
    if (reg_we && aligned) begin
      if (idx == IX_IRQ_EN)  ie_d   = reg_wdata[NUM_CH-1:0];
      if (idx == IX_WDOG_EN) wden_d = reg_wdata[0];
      if (idx == IX_DIV)     div_d  = reg_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ie_q   <= '0;
      wden_q <= 1'b0;
      div_q  <= '0;
    end else begin
      ie_q   <= ie_d;
      wden_q <= wden_d;
      div_q  <= div_d;
    end
  end

  tmr_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .div_i  (div_q),
    .tick_o (tick)
  );

  tmr_count64 u_count (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .tick_i    (tick),
    .wr_i      (cnt_wr),
    .snap_i    (snap_cmd),
    .cnt_lo_o  (cnt_lo),
    .cnt_hi_o  (cnt_hi),
    .snap_lo_o (snap_lo),
    .snap_hi_o (snap_hi),
    .inc_o     (inc),
    .next_lo_o (next_lo)
  );

  tmr_compare #(.NUM_CH(NUM_CH)) u_compare (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .inc_i      (inc),
    .next_lo_i  (next_lo),
    .match_we_i (match_we),
    .wdata_i    (reg_wdata),
    .clr_i      (clr),
    .match_o    (match),
    .status_o   (status)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      unique case (idx)
        IX_CNT_LO:  reg_rdata = cnt_lo;
        IX_CNT_HI:  reg_rdata = cnt_hi;
        IX_STATUS:  reg_rdata = WORD_W'(status);
        IX_IRQ_EN:  reg_rdata = WORD_W'(ie_q);
        IX_WDOG_EN: reg_rdata = WORD_W'(wden_q);
        IX_DIV:     reg_rdata = WORD_W'(div_q);
        IX_SNAP_LO: reg_rdata = snap_lo;
        IX_SNAP_HI: reg_rdata = snap_hi;
        default: begin
          for (int n = 0; n < NUM_CH; n++)
            if (idx == IX_MATCH0 + IDX_W'(n)) reg_rdata = match[n];
        end
      endcase
    end
  end

  assign tmr_irq  = status & ie_q;
  assign wdog_rst = wden_q && status[WDOG_CH];

  p_wdog_quiet_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!wden_q && !wden_d) |=> !wdog_rst);
endmodule

// File: tb/test_sys_timer.sv
`timescale 1ns/100ps
module test_sys_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [5:0]  tmr_irq;
  logic        wdog_rst;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sys_timer #(.NUM_CH(6), .DIV_W(8)) i_sys_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .tmr_irq   (tmr_irq),
    .wdog_rst  (wdog_rst)
  );

  localparam logic [7:0] A_LO = 8'h00, A_HI = 8'h04, A_M0 = 8'h08, A_ST = 8'h20,
                         A_IE = 8'h24, A_WD = 8'h28, A_DIV = 8'h2C, A_SNAP = 8'h30,
                         A_SLO = 8'h34, A_SHI = 8'h38;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; the write lands on the next rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (i_addrs[k]) begin
      rd(i_addrs[k], v);
      chk($sformatf("R1 addr %h", i_addrs[k]), v, 32'h0);
    end
    chk("R1 irq", {26'h0, tmr_irq}, 32'h0);
    chk("R1 wdog", {31'h0, wdog_rst}, 32'h0);
  endtask
  logic [7:0] i_addrs [15] = '{A_HI, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, A_ST,
                               A_IE, A_WD, A_DIV, A_SLO, A_SHI, 8'h3C, 8'h81};

  task automatic t_prescale(input logic [31:0] d);
    logic [31:0] v0, v;
    int n;
    wr(A_DIV, d);
    rd(A_LO, v0);
    n = 0;
    do begin @(negedge clk); rd(A_LO, v); n++; end while (v == v0 && n < 2000);
    v0 = v;
    n = 0;
    do begin @(negedge clk); rd(A_LO, v); n++; end while (v == v0 && n < 2000);
    chk($sformatf("R2 period D=%0d", d), n, 2 * (d + 1));
  endtask

  task automatic t_write;
    logic [31:0] v;
    wr(A_DIV, 0);
    wr(A_HI, 32'h12);
    wr(A_LO, 32'h100);
    rd(A_LO, v); chk("R3 lo write A", v, 32'h100);
    @(negedge clk);
    wr(A_LO, 32'h200);
    rd(A_LO, v); chk("R3 lo write B", v, 32'h200);
    rd(A_HI, v); chk("R3 hi write", v, 32'h12);
  endtask

  task automatic t_carry;
    logic [31:0] v, h;
    int n;
    wr(A_DIV, 0);
    wr(A_HI, 32'h7);
    wr(A_LO, 32'hFFFF_FFFC);
    n = 0;
    do begin @(negedge clk); rd(A_LO, v); rd(A_HI, h); n++; end
      while (v >= 32'hFFFF_FFF0 && n < 40);
    chk("R4 low after wrap", v, 32'h0);
    chk("R4 high carry", h, 32'h8);
  endtask

  task automatic t_snap;
    logic [31:0] v, s;
    wr(A_DIV, 0);
    wr(A_HI, 32'h3);
    wr(A_LO, 32'h50);
    rd(A_LO, v);
    wr(A_SNAP, 32'h1);
    rd(A_SLO, s); chk("R5 snap low", s, v);
    rd(A_SHI, s); chk("R5 snap high", s, 32'h3);
    idle(20);
    rd(A_SLO, s); chk("R5 snap low held", s, v);
    wr(A_SNAP, 32'h0);
    idle(2);
    rd(A_SLO, s); chk("R5 bit0 zero no capture", s, v);
  endtask

  task automatic t_match;
    logic [31:0] v, st;
    int n;
    wr(A_DIV, 0);
    wr(A_IE, 0);
    wr(A_ST, 32'h3F);
    wr(A_HI, 32'h5);
    wr(A_LO, 32'd10);
    wr(A_M0, 32'd20);
    n = 0;
    do begin @(negedge clk); rd(A_ST, st); rd(A_LO, v); n++; end
      while (!st[0] && n < 60);
    chk("R6 status on hit", st[0], 1'b1);
    chk("R10 hit with high word 5, low at match", v, 32'd20);
    // R7 write-one-to-clear
    wr(A_ST, 32'h0);  rd(A_ST, st); chk("R7 zero write keeps", st[0], 1'b1);
    wr(A_ST, 32'h2);  rd(A_ST, st); chk("R7 other bit keeps", st[0], 1'b1);
    wr(A_ST, 32'h1);  rd(A_ST, st); chk("R7 one clears", st[0], 1'b0);
    // R6 once per hit with a slow prescaler
    wr(A_DIV, 50);
    wr(A_LO, 32'd30);
    wr(8'h0C, 32'd31);
    n = 0;
    do begin @(negedge clk); rd(A_ST, st); n++; end while (!st[1] && n < 300);
    chk("R6 slow hit", st[1], 1'b1);
    wr(A_ST, 32'h2);
    idle(40);
    rd(A_ST, st); chk("R6 no refire while idle", st[1], 1'b0);
    rd(A_LO, v);  chk("R6 count still on match", v, 32'd31);
    // R10 past value not hit
    wr(A_DIV, 0);
    wr(8'h10, 32'd5);
    wr(A_LO, 32'd100);
    idle(60);
    rd(A_ST, st); chk("R10 past match quiet", st[2], 1'b0);
  endtask

  task automatic t_irq;
    logic [31:0] st;
    wr(A_DIV, 0);
    wr(A_ST, 32'h3F);
    wr(A_IE, 32'h1);
    wr(A_LO, 32'd0);
    wr(A_M0, 32'd6);
    idle(20);
    chk("R8 irq0 raised", {26'h0, tmr_irq}, 32'h1);
    wr(A_IE, 32'h0);
    #0.5;
    chk("R8 irq0 masked", {26'h0, tmr_irq}, 32'h0);
    rd(A_ST, st); chk("R8 status kept under mask", st[0], 1'b1);
  endtask

  task automatic t_wdog;
    logic [31:0] st;
    wr(A_DIV, 0);
    wr(A_ST, 32'h3F);
    wr(A_WD, 32'h0);
    wr(A_LO, 32'd0);
    wr(8'h1C, 32'd8);
    idle(20);
    rd(A_ST, st); chk("R9 status5 without enable", st[5], 1'b1);
    chk("R9 no reset without enable", {31'h0, wdog_rst}, 32'h0);
    wr(A_ST, 32'h20);
    wr(A_WD, 32'h1);
    wr(A_LO, 32'd0);
    idle(20);
    #0.5;
    chk("R9 reset raised", {31'h0, wdog_rst}, 32'h1);
    chk("R9 irq5 stays masked", {31'h0, tmr_irq[5]}, 32'h0);
    wr(A_ST, 32'h20);
    #0.5;
    chk("R9 reset drops on clear", {31'h0, wdog_rst}, 32'h0);
  endtask

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 8'h0; reg_wdata = 32'h0;
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset;
    t_prescale(0);
    t_prescale(3);
    t_prescale(6);
    t_write;
    t_carry;
    t_snap;
    t_match;
    t_irq;
    t_wdog;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule